// File: doc/BRIEF.md
# Reset Vector Jump Sequencer

After a power-on or reset, a processor usually starts fetching from a fixed low address. This block takes over those first fetches. It puts a short instruction stream on the data bus: a disable-interrupts opcode, then a jump opcode, then a zero low-address byte, then a high-address byte read from an 8-bit page switch bank. The processor therefore lands on any 256-byte page from 0000h to FF00h that the switches select.

While the stream runs, the block does two more things. It raises an overlay-disable (phantom) output so that every other memory on the bus stays quiet, and it raises a ROM-inhibit output that turns off its own ROM chip selects. The read data strobe acts as the step clock. Each completed read, meaning the strobe's falling edge sampled on the system clock, moves the sequence one step on. The fifth completed read ends the sequence.

A configuration bit picks the source of the sequencer clear: either the system reset or the power-on clear, both active low. A jump-enable switch arms the feature. When it is open, a clear leaves the block idle. The power-on clear also brings the block's registers to idle in every configuration.

Top module: `vjs_top`

## Requirements
- R1: With `por_n` held low while `clr_sel`=1, the block is idle once `por_n` is released: `dout_oe`=0, `dout`=00h, `phantom`=0, `rom_inhibit`=0. Strobes given while idle change none of these outputs.
- R2: With `jump_en`=1, one clock edge with the selected clear low arms the sequence at step 0. The outputs are then `dout_oe`=1, `dout`=F3h, `phantom`=1 and `rom_inhibit`=1, and they stay so while the clear is held and after it is released.
- R3: Each completed strobe advances the sequence by exactly one step. A completed strobe is `rd_strobe` seen high on one clock edge and low on the next. The bytes driven while the four reads are high are, in order: F3h, C3h, 00h, page byte.
- R4: The page byte equals `page_sw`, with bit i taken from `page_sw[i]` (switch closed = 1). The jump target is therefore `page_sw`×256.
- R5: After the fourth completed strobe, `dout_oe`=0 and `dout`=00h, while `phantom` and `rom_inhibit` stay at 1. The fifth completed strobe returns `phantom` and `rom_inhibit` to 0.
- R6: `clr_sel`=1 makes `sys_reset_n` the sequencer clear, and `clr_sel`=0 makes `por_n` the sequencer clear. A low level on the unselected signal does not start a sequence.
- R7: With `jump_en`=0, a low level on the selected clear leaves the block idle (all outputs as in R1).
- R8: A selected clear that goes low in the middle of a sequence restarts it at the F3h step.
- R9: A strobe held high over many clocks advances the sequence only once, when it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on clear, active low; also brings the block's registers to idle |
| sys_reset_n | input | 1 | System reset, active low |
| clr_sel | input | 1 | 1: system reset is the sequencer clear; 0: power-on clear is |
| jump_en | input | 1 | Jump-enable switch, 1 = closed (feature armed) |
| page_sw | input | 8 | Page switch bank, closed = 1; supplies the jump high-address byte |
| rd_strobe | input | 1 | Read data strobe, active high |
| dout | output | 8 | Byte driven onto the data bus (00h when not driving) |
| dout_oe | output | 1 | Output enable for `dout` |
| phantom | output | 1 | Overlay-disable output that silences other memory, active high |
| rom_inhibit | output | 1 | Turns off the ROM chip selects, active high |

## Verification
The hardest situation to reach from the ports is a clear that arrives in the middle of a sequence, after some bytes have already been delivered. The bench gets there by giving two reads, pulsing the system reset with the feature armed, and then checking that the next read again returns F3h. The long-held strobe and the fifth-strobe release are reached by driving the strobe directly, without any processor model. The table loop also switches the clear source from one entry to the next, so that both ways of starting the sequence run against several page patterns.

// File: rtl/vjs_pkg.sv
package vjs_pkg;

  localparam int VJS_BYTE_W  = 8;
  localparam int VJS_N_BYTES = 4;
  localparam int VJS_STEPS   = VJS_N_BYTES + 1;
  localparam int VJS_STEP_W  = $clog2(VJS_STEPS);

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } vjs_phase_e;

  // Byte emitted at a given step; steps past the stream give zero.
  function automatic logic [VJS_BYTE_W-1:0] vjs_pick_byte(
    input logic [VJS_STEP_W-1:0] step,
    input logic [VJS_BYTE_W-1:0] page,
    input logic [VJS_BYTE_W-1:0] op_di,
    input logic [VJS_BYTE_W-1:0] op_jmp,
    input logic [VJS_BYTE_W-1:0] lo_addr
  );
    logic [VJS_BYTE_W-1:0] b;
    case (step)
      VJS_STEP_W'(0): b = op_di;
      VJS_STEP_W'(1): b = op_jmp;
      VJS_STEP_W'(2): b = lo_addr;
      VJS_STEP_W'(3): b = page;
      default:        b = '0;
    endcase
    return b;
  endfunction

  // True when a step still drives a byte.
  function automatic logic vjs_step_drives(input logic [VJS_STEP_W-1:0] step);
    return (int'(step) < VJS_N_BYTES);
  endfunction

endpackage

// File: rtl/vjs_clear_sel.sv
module vjs_clear_sel (
  input  logic clr_sel,
  input  logic por_n,
  input  logic sys_reset_n,
  input  logic jump_en,
  output logic seq_clr_n,
  output logic start_req
);
  always_comb begin
    seq_clr_n = clr_sel ? sys_reset_n : por_n;
    start_req = jump_en & ~seq_clr_n;
  end
endmodule

// File: rtl/vjs_strobe_edge.sv
module vjs_strobe_edge (
  input  logic clk,
  input  logic por_n,
  input  logic strobe,
  output logic done_pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!por_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign done_pulse = prev_q & ~strobe;
endmodule

// File: rtl/vjs_step_seq.sv
module vjs_step_seq
  import vjs_pkg::*;
#(
  parameter int STEP_W    = VJS_STEP_W,
  parameter int LAST_STEP = VJS_STEPS - 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              start_req,
  input  logic              advance,
  output logic              active,
  output logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(LAST_STEP);

  vjs_phase_e        ph_q;
  logic [STEP_W-1:0] step_q;
  logic              at_last;

  assign at_last = (step_q == LAST);

  always_ff @(posedge clk) begin
    if (start_req) begin
      ph_q   <= PH_RUN;
      step_q <= '0;
    end else if (!por_n) begin
      ph_q   <= PH_IDLE;
      step_q <= '0;
    end else if (ph_q == PH_RUN && advance) begin
      if (at_last) begin
        ph_q   <= PH_IDLE;
        step_q <= '0;
      end else begin
        step_q <= step_q + STEP_W'(1);
      end
    end
  end

  assign active = (ph_q == PH_RUN);
  assign step   = step_q;

  // R3
  step_adv_chk: assert property (@(posedge clk) disable iff (!por_n)
    (active && advance && !start_req && !at_last) |=> (step == $past(step) + STEP_W'(1)));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!por_n)
    (active && advance && !start_req && at_last) |=> !active);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (active && !advance && !start_req) |=> ($stable(step) && active));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    start_req |=> (active && step == '0));

  // R1
  idle_stay_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!active && !start_req) |=> !active);
endmodule

// File: rtl/vjs_byte_drive.sv
module vjs_byte_drive
  import vjs_pkg::*;
#(
  parameter logic [VJS_BYTE_W-1:0] OP_DI   = 8'hF3,
  parameter logic [VJS_BYTE_W-1:0] OP_JMP  = 8'hC3,
  parameter logic [VJS_BYTE_W-1:0] LO_ADDR = 8'h00
) (
  input  logic                  active,
  input  logic [VJS_STEP_W-1:0] step,
  input  logic [VJS_BYTE_W-1:0] page_sw,
  output logic [VJS_BYTE_W-1:0] dout,
  output logic                  dout_oe
);
  always_comb begin
    dout_oe = active & vjs_step_drives(step);
    dout    = dout_oe ? vjs_pick_byte(step, page_sw, OP_DI, OP_JMP, LO_ADDR) : '0;
  end
endmodule

// File: rtl/vjs_top.sv
module vjs_top
  import vjs_pkg::*;
#(
  parameter logic [VJS_BYTE_W-1:0] OP_DI   = 8'hF3,
  parameter logic [VJS_BYTE_W-1:0] OP_JMP  = 8'hC3,
  parameter logic [VJS_BYTE_W-1:0] LO_ADDR = 8'h00
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  sys_reset_n,
  input  logic                  clr_sel,
  input  logic                  jump_en,
  input  logic [VJS_BYTE_W-1:0] page_sw,
  input  logic                  rd_strobe,
  output logic [VJS_BYTE_W-1:0] dout,
  output logic                  dout_oe,
  output logic                  phantom,
  output logic                  rom_inhibit
);
  logic                  seq_clr_n;
  logic                  start_req;
  logic                  read_done;
  logic                  seq_active;
  logic [VJS_STEP_W-1:0] seq_step;

  vjs_clear_sel u_clr (
    .clr_sel     (clr_sel),
    .por_n       (por_n),
    .sys_reset_n (sys_reset_n),
    .jump_en     (jump_en),
    .seq_clr_n   (seq_clr_n),
    .start_req   (start_req)
  );

  vjs_strobe_edge u_edge (
    .clk        (clk),
    .por_n      (por_n),
    .strobe     (rd_strobe),
    .done_pulse (read_done)
  );

  vjs_step_seq u_seq (
    .clk       (clk),
    .por_n     (por_n),
    .start_req (start_req),
    .advance   (read_done),
    .active    (seq_active),
    .step      (seq_step)
  );

  vjs_byte_drive #(
    .OP_DI   (OP_DI),
    .OP_JMP  (OP_JMP),
    .LO_ADDR (LO_ADDR)
  ) u_drv (
    .active  (seq_active),
    .step    (seq_step),
    .page_sw (page_sw),
    .dout    (dout),
    .dout_oe (dout_oe)
  );

  assign phantom     = seq_active;
  assign rom_inhibit = seq_active;

  // R2
  start_drive_chk: assert property (@(posedge clk) disable iff (!por_n)
    start_req |=> (dout_oe && dout == OP_DI && phantom && rom_inhibit));

  // R7
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!jump_en && !phantom) |=> !phantom);

  // R6
  seq_clr_src_chk: assert property (@(posedge clk) disable iff (!por_n)
    (jump_en && !phantom && clr_sel && sys_reset_n) |=> !dout_oe);
endmodule

// File: tb/vjs_top_tb.sv
module vjs_top_tb;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sys_reset_n = 1'b1;
  logic       clr_sel = 1'b1;
  logic       jump_en = 1'b0;
  logic [7:0] page_sw = 8'h00;
  logic       rd_strobe = 1'b0;
  logic [7:0] dout;
  logic       dout_oe, phantom, rom_inhibit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vjs_top u_dut (
    .clk(clk), .por_n(por_n), .sys_reset_n(sys_reset_n), .clr_sel(clr_sel),
    .jump_en(jump_en), .page_sw(page_sw), .rd_strobe(rd_strobe),
    .dout(dout), .dout_oe(dout_oe), .phantom(phantom), .rom_inhibit(rom_inhibit)
  );

  // Table entries: {clear source select, page switch byte}
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'h00}, {1'b0, 8'hFF}, {1'b1, 8'h5A},
    {1'b0, 8'hA5}, {1'b1, 8'h01}, {1'b0, 8'h80}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic oe, input logic [7:0] d, input logic ph);
    chk({tag, " oe"}, {7'd0, dout_oe}, {7'd0, oe});
    chk({tag, " dout"}, dout, d);
    chk({tag, " phantom"}, {7'd0, phantom}, {7'd0, ph});
    chk({tag, " inhibit"}, {7'd0, rom_inhibit}, {7'd0, ph});
  endtask

  // One read: strobe high for one cycle, capture the bus while high, then drop.
  task automatic do_read(output logic [7:0] seen, output logic seen_oe);
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); seen = dout; seen_oe = dout_oe; rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  // Pulse the selected clear low for two cycles.
  task automatic pulse_clear(input logic use_reset);
    @(negedge clk);
    if (use_reset) sys_reset_n = 1'b0; else por_n = 1'b0;
    @(negedge clk); @(negedge clk);
    sys_reset_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic       o;
    logic [7:0] exp_seq [4];

    // R1: power-on with the system reset as clear source leaves the block idle
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    chk_state("R1 reset", 1'b0, 8'h00, 1'b0);
    do_read(b, o);
    chk("R1 idle read oe", {7'd0, o}, 8'h00);
    chk_state("R1 after idle read", 1'b0, 8'h00, 1'b0);

    // R3 R4 R5 R6: table of clear source and page patterns
    jump_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      clr_sel = VEC[i][8];
      page_sw = VEC[i][7:0];
      exp_seq[0] = 8'hF3; exp_seq[1] = 8'hC3; exp_seq[2] = 8'h00; exp_seq[3] = VEC[i][7:0];
      pulse_clear(VEC[i][8]);
      chk_state("R2 R6 armed", 1'b1, 8'hF3, 1'b1);
      for (int k = 0; k < 4; k++) begin
        do_read(b, o);
        chk("R3 R4 byte", b, exp_seq[k]);
        chk("R3 oe during read", {7'd0, o}, 8'h01);
      end
      chk_state("R5 after fourth", 1'b0, 8'h00, 1'b1);
      do_read(b, o);
      chk("R5 fifth read oe", {7'd0, o}, 8'h00);
      chk_state("R5 released", 1'b0, 8'h00, 1'b0);
    end

    // R7: feature switch open, clear has no effect
    jump_en = 1'b0; clr_sel = 1'b1;
    pulse_clear(1'b1);
    chk_state("R7 unarmed", 1'b0, 8'h00, 1'b0);

    // R6: unselected clear source does not start the sequence
    jump_en = 1'b1; clr_sel = 1'b0;
    pulse_clear(1'b1);
    chk_state("R6 unselected reset", 1'b0, 8'h00, 1'b0);

    // R8: restart in the middle of a sequence
    clr_sel = 1'b1; page_sw = 8'h3C;
    pulse_clear(1'b1);
    do_read(b, o); chk("R8 first", b, 8'hF3);
    do_read(b, o); chk("R8 second", b, 8'hC3);
    pulse_clear(1'b1);
    chk_state("R8 restarted", 1'b1, 8'hF3, 1'b1);
    do_read(b, o); chk("R8 after restart", b, 8'hF3);

    // R9: long strobe advances only once
    @(negedge clk); rd_strobe = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 held strobe byte", dout, 8'hC3);
    rd_strobe = 1'b0;
    @(negedge clk);
    chk("R9 after long strobe", dout, 8'h00);
    do_read(b, o); chk("R9 next", b, 8'h00);
    do_read(b, o); chk("R4 page", b, 8'h3C);
    do_read(b, o);
    chk_state("R5 end", 1'b0, 8'h00, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule